// File: doc/BRIEF.md
# Half-Bridge Dead-Time Guard

This block sits between the gate requests for one leg of a half bridge and the enables that actually switch the high-side and low-side transistors. A request to turn one transistor on is held back until the other transistor's enable has been low for a minimum dead time. A request to turn a transistor off goes through on the next clock. If both transistors are requested at once, the block drives both enables low and raises a conflict flag.

The dead time is counted in clock ticks. A 2-bit base code selects 1, 2, 4 or 8 base units, where one unit is `BASE_TICKS` clocks (200 ns at the default parameters). A 2-bit scale code then multiplies that by 1, 2 or 4. A protection-off input bypasses the counted dead time. A static interlock stays in force in that mode: an enable can only rise at an edge where the other enable was already low, so the gap between the two is always at least one clock.

Top module: `leg_deadtime_guard`

## Requirements
- R1: While `rst` is high, and at the first sample after it, `hi_en`, `lo_en` and `overlap_flag` are 0.
- R2: `hi_en` and `lo_en` are never 1 in the same cycle, in either mode.
- R3: At every clock edge where both `hi_req` and `lo_req` are 1, both enables go to 0 and `overlap_flag` goes to 1 for that cycle. At any other edge, `overlap_flag` goes to 0.
- R4: At a clock edge where a side's request is 0, that side's enable goes to 0.
- R5: With `dyn_off` = 0, an enable rises at the first edge where three things are true: its request is 1, the other request is 0, and the other enable has been low for `need` full cycles. `need` = `BASE_TICKS` × base factor × scale factor. The number of sampled cycles with both enables low between one enable falling and the other rising is exactly `need`.
- R6: `base_sel` codes 0, 1, 2 and 3 give base factors 1, 2, 4 and 8.
- R7: `scale_sel` codes 0, 1 and 2 give scale factors 1, 2 and 4. Code 3 is treated as 4.
- R8: With `dyn_off` = 1, an enable rises at the first edge where its request is 1, the other request is 0 and the other enable was already 0. The gap is one cycle, whatever the time codes are.
- R9: When reset ends, both sides count as having just turned off. With `dyn_off` = 0, the first turn-on waits `need` cycles from the release of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hi_req | input | 1 | Requested state of the high-side gate |
| lo_req | input | 1 | Requested state of the low-side gate |
| base_sel | input | 2 | Base dead-time code (factor 1/2/4/8) |
| scale_sel | input | 2 | Scale code (×1/×2/×4, 3 treated as ×4) |
| dyn_off | input | 1 | 1 bypasses the counted dead time; static interlock stays |
| hi_en | output | 1 | Registered high-side gate enable |
| lo_en | output | 1 | Registered low-side gate enable |
| overlap_flag | output | 1 | Registered flag: both gates were requested at the last edge |

## Verification
The bench measures the gap in cycles for all sixteen time-code pairs and in both switching directions. An off-by-one in the counter compare would show up as a gap of `need`±1. A wrong decode of scale code 3 would show up as a gap too short by half. In protection-off mode the bench checks that the gap collapses to exactly one cycle. A design that dropped the static interlock would give a gap of zero, and both enables could be seen high together. The bench also checks the first turn-on after reset, which a counter reset to its saturated value would let through at once. It applies simultaneous requests to check that both enables fall and that the flag lasts only as long as the conflict.

// File: rtl/ddt_pkg.sv
package ddt_pkg;
  // Number of gate sides in one leg; index 0 is low side, 1 is high side.
  localparam int SIDES = 2;
  localparam int SEL_W = 2;
  // Largest combined factor: base 8 times scale 4.
  localparam int MAX_FACTOR = 32;

  // Left shift for the scale code; the reserved code behaves like x4.
  function automatic logic [1:0] scale_shift(input logic [SEL_W-1:0] code);
    return (code == 2'd3) ? 2'd2 : code;
  endfunction
endpackage

// File: rtl/ddt_span.sv
module ddt_span
  import ddt_pkg::*;
#(
  parameter int BASE_TICKS = 40,
  parameter int CNT_W      = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] base_sel,
  input  logic [SEL_W-1:0] scale_sel,
  output logic [CNT_W-1:0] need
);
  logic [2:0] shamt;

  always_comb begin
    shamt = 3'(base_sel) + 3'(scale_shift(scale_sel));
    need  = CNT_W'(BASE_TICKS) << shamt;
  end

  // R6 / R7: the scaled time stays between one base unit and the max factor
  p_need_range_r6: assert property (@(posedge clk) disable iff (rst)
    (need >= CNT_W'(BASE_TICKS)) && (need <= CNT_W'(BASE_TICKS * MAX_FACTOR)));
endmodule

// File: rtl/ddt_offrun.sv
module ddt_offrun #(
  parameter int CNT_W = 11,
  parameter int MAXV  = 1280
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  output logic [CNT_W-1:0] cnt
);
  // Counts cycles since this side's enable was last high, saturating.
  always_ff @(posedge clk) begin
    if (rst || en)
      cnt <= '0;
    else if (cnt != CNT_W'(MAXV))
      cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/ddt_arbiter.sv
module ddt_arbiter
  import ddt_pkg::*;
#(
  parameter int CNT_W = 11
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [SIDES-1:0]           req,
  input  logic                       dyn_off,
  input  logic [CNT_W-1:0]           need,
  input  logic [SIDES-1:0][CNT_W-1:0] run,
  output logic [SIDES-1:0]           en,
  output logic                       flag
);
  logic             both;
  logic [SIDES-1:0] go;

  assign both = &req;

  for (genvar i = 0; i < SIDES; i++) begin : g_side
    localparam int OPP = SIDES - 1 - i;
    logic settled;
    assign settled = dyn_off | (run[OPP] >= (need - CNT_W'(1)));
    assign go[i]   = req[i] & ~req[OPP] & ~en[OPP] & settled;

    // R4: a dropped request clears its enable at the next edge
    p_release_r4: assert property (@(posedge clk) disable iff (rst)
      !req[i] |=> !en[i]);
    // R8: an enable only rises if the other one was already low
    p_static_gap_r8: assert property (@(posedge clk) disable iff (rst)
      $rose(en[i]) |-> !$past(en[OPP]));
    // R5: with the counted dead time active, the other side was off long enough
    p_dyn_wait_r5: assert property (@(posedge clk) disable iff (rst)
      ($rose(en[i]) && !$past(dyn_off)) |->
        ($past(run[OPP]) >= ($past(need) - CNT_W'(1))));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en   <= '0;
      flag <= 1'b0;
    end else begin
      en   <= go;
      flag <= both;
    end
  end

  // R2: never both gates on
  p_exclusive_r2: assert property (@(posedge clk) disable iff (rst)
    !(en[0] && en[1]));
  // R3: conflicting requests drop both enables and raise the flag
  p_clash_r3: assert property (@(posedge clk) disable iff (rst)
    both |=> (flag && (en == '0)));
  p_flag_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    !both |=> !flag);
endmodule

// File: rtl/leg_deadtime_guard.sv
module leg_deadtime_guard
  import ddt_pkg::*;
#(
  parameter int BASE_TICKS = 40
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       hi_req,
  input  logic       lo_req,
  input  logic [1:0] base_sel,
  input  logic [1:0] scale_sel,
  input  logic       dyn_off,
  output logic       hi_en,
  output logic       lo_en,
  output logic       overlap_flag
);
  localparam int MAXV  = BASE_TICKS * MAX_FACTOR;
  localparam int CNT_W = $clog2(MAXV + 1);

  logic [CNT_W-1:0]            need;
  logic [SIDES-1:0]            en;
  logic [SIDES-1:0][CNT_W-1:0] run;

  ddt_span #(.BASE_TICKS(BASE_TICKS), .CNT_W(CNT_W)) u_span (
    .clk(clk), .rst(rst), .base_sel(base_sel), .scale_sel(scale_sel), .need(need)
  );

  for (genvar i = 0; i < SIDES; i++) begin : g_run
    ddt_offrun #(.CNT_W(CNT_W), .MAXV(MAXV)) u_run (
      .clk(clk), .rst(rst), .en(en[i]), .cnt(run[i])
    );
  end

  ddt_arbiter #(.CNT_W(CNT_W)) u_arb (
    .clk(clk), .rst(rst), .req({hi_req, lo_req}), .dyn_off(dyn_off),
    .need(need), .run(run), .en(en), .flag(overlap_flag)
  );

  assign lo_en = en[0];
  assign hi_en = en[1];
endmodule

// File: tb/leg_deadtime_guard_test.sv
`timescale 1ns/1ps
module leg_deadtime_guard_test;
  localparam int BT = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hi_req = 1'b0, lo_req = 1'b0, dyn_off = 1'b0;
  logic [1:0] base_sel = 2'd0, scale_sel = 2'd0;
  logic hi_en, lo_en, overlap_flag;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // Reference state
  bit m_hi = 0, m_lo = 0, m_flag = 0;
  int gap_hi = 0, gap_lo = 0;

  always #2.5 clk = ~clk;

  leg_deadtime_guard #(.BASE_TICKS(BT)) uut (
    .clk(clk), .rst(rst), .hi_req(hi_req), .lo_req(lo_req),
    .base_sel(base_sel), .scale_sel(scale_sel), .dyn_off(dyn_off),
    .hi_en(hi_en), .lo_en(lo_en), .overlap_flag(overlap_flag)
  );

  function automatic int need_of(input int b, input int m);
    int f;
    f = (m == 3) ? 4 : (1 << m);
    return BT * (1 << b) * f;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Behavioural reference, advanced on each rising edge
  always @(posedge clk) begin
    bit n_hi, n_lo;
    int need;
    if (rst) begin
      m_hi = 0; m_lo = 0; m_flag = 0; gap_hi = 0; gap_lo = 0;
    end else begin
      need   = need_of(base_sel, scale_sel);
      n_hi   = hi_req && !lo_req && !m_lo && (dyn_off || (gap_lo + 1 >= need));
      n_lo   = lo_req && !hi_req && !m_hi && (dyn_off || (gap_hi + 1 >= need));
      m_flag = hi_req && lo_req;
      gap_hi = m_hi ? 0 : gap_hi + 1;
      gap_lo = m_lo ? 0 : gap_lo + 1;
      m_hi   = n_hi;
      m_lo   = n_lo;
    end
  end

  // Compare on every cycle, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(hi_en == m_hi, "R5 model hi_en", hi_en, m_hi);
      chk(lo_en == m_lo, "R5 model lo_en", lo_en, m_lo);
      chk(overlap_flag == m_flag, "R3 model flag", overlap_flag, m_flag);
      chk(!(hi_en && lo_en), "R2 exclusive", hi_en + lo_en, 1);
    end
  end

  // Switch from opposite side to target side; return dead gap in cycles
  task automatic measure(input bit to_hi, input int b, input int m, input bit stat,
                         input int exp, input string tag);
    int gap;
    base_sel = 2'(b); scale_sel = 2'(m); dyn_off = stat;
    hi_req = !to_hi; lo_req = to_hi;
    @(negedge clk);
    while (!(to_hi ? lo_en : hi_en)) @(negedge clk);
    hi_req = to_hi; lo_req = !to_hi;
    gap = 0;
    @(negedge clk);
    while (!(to_hi ? hi_en : lo_en)) begin
      if (!hi_en && !lo_en) gap++;
      @(negedge clk);
    end
    chk(gap == exp, tag, gap, exp);
  endtask

  initial begin
    int cnt;
    // R1: reset state
    hi_req = 1'b1;
    base_sel = 2'd1; scale_sel = 2'd1;
    repeat (4) @(negedge clk);
    chk(!hi_en && !lo_en && !overlap_flag, "R1 in reset", {hi_en, lo_en, overlap_flag}, 0);
    // R9: first turn-on after reset waits the full time
    rst = 1'b0;
    chk(!hi_en && !lo_en && !overlap_flag, "R1 after release", {hi_en, lo_en, overlap_flag}, 0);
    cnt = 0;
    while (!hi_en) begin cnt++; @(negedge clk); end
    chk(cnt == need_of(1, 1), "R9 post-reset wait", cnt, need_of(1, 1));

    // R5 R6 R7: all code pairs, both directions
    for (int b = 0; b < 4; b++)
      for (int m = 0; m < 4; m++) begin
        measure(1'b1, b, m, 1'b0, need_of(b, m), "R6/R7 gap to high side");
        measure(1'b0, b, m, 1'b0, need_of(b, m), "R5 gap to low side");
      end

    // R8: static interlock only
    measure(1'b1, 3, 2, 1'b1, 1, "R8 static gap high");
    measure(1'b0, 3, 3, 1'b1, 1, "R8 static gap low");
    measure(1'b1, 0, 0, 1'b1, 1, "R8 static gap short code");

    // R4: turn-off on next clock
    dyn_off = 1'b0;
    hi_req = 1'b0; lo_req = 1'b1;
    @(negedge clk);
    while (!lo_en) @(negedge clk);
    lo_req = 1'b0;
    @(negedge clk);
    chk(!lo_en, "R4 immediate turn-off", lo_en, 0);

    // R3: both requested
    dyn_off = 1'b1;
    hi_req = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(hi_en, "R3 setup high on", hi_en, 1);
    lo_req = 1'b1;
    @(negedge clk);
    chk(!hi_en && !lo_en && overlap_flag, "R3 clash drops both",
        {hi_en, lo_en, overlap_flag}, 1);
    @(negedge clk);
    chk(overlap_flag, "R3 flag held while clash", overlap_flag, 1);
    hi_req = 1'b0; lo_req = 1'b0;
    @(negedge clk);
    chk(!overlap_flag, "R3 flag clears", overlap_flag, 0);
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule